// File: doc/BRIEF.md
# Two-Level SMI Status Aggregator

This block gathers five power-management event sources into one second-level status word. It raises a top-level summary flag and a level-sensitive SMI request while any recorded event is still pending. Four of the sources pass through enable bits that the block holds itself. The fifth, a write to the SMI command port, is always recorded.

Software reaches the block through a small register port. The port has a read strobe, a write strobe, a two-bit address and sixteen bits of data. The same status word can be read in two ways. A destructive read returns the word and then empties it, which also drops the summary flag and the SMI request. A mirror read returns the same word and changes nothing.

An event that arrives in the same cycle as a destructive read is kept, so no event is lost.

Top module: `smi_status_hub`

## Requirements
- R1: After reset the status word reads 0000h, the top-level word reads 0000h, `smi_active` is 0, and the enable register reads 001Ch.
- R2: Status bits 15:6 and bit 3 always read as 0.
- R3: Status bit 5 sets on `evt_bios_raise` only when enable bits 0 and 1 are both 1.
- R4: Status bit 4 sets on `evt_idle3_read` when enable bit 2 is 1. Bit 2 sets on `evt_sleep_set` when enable bit 3 is 1. Bit 1 sets on `evt_throttle_set` when enable bit 4 is 1. An event whose enable is 0 sets nothing.
- R5: Status bit 0 sets on every `evt_smicmd_wr`, whatever the enables hold.
- R6: A read at address 0 (mirror) returns the status word and leaves the status, the top-level word and `smi_active` unchanged.
- R7: A read at address 1 returns the status word as it was before the read. From the next cycle, the status word, the top-level summary bit and `smi_active` are 0, unless an event arrived in that same cycle.
- R8: When an enabled event arrives in the same cycle as a read at address 1, its status bit is 1 after the clear.
- R9: The top-level word, on `top_status` and at address 3, has bit 2 equal to the OR of all status bits and every other bit 0.
- R10: `smi_active` is a registered level. In every cycle it equals 1 exactly when the status word is nonzero, so it rises on the clock edge that records an event.
- R11: Writes to address 0, address 1 and address 3 have no effect on the status word or on the enables.
- R12: Address 2 holds the enables and can be read and written. Bit 0 is BIOS-raise enable A, bit 1 is BIOS-raise enable B, bit 2 is the idle-3 enable, bit 3 is the sleep enable and bit 4 is the throttle enable. Written bits 15:5 are dropped and read as 0.
- R13: `reg_rdata` is combinational. It shows the register selected by `reg_addr` in the current cycle, whether or not a strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | Read strobe. At address 1 it clears the status on the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | 0 mirror, 1 clear-on-read, 2 enables, 3 top-level word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected address |
| evt_bios_raise | input | 1 | Request from ACPI software to BIOS |
| evt_idle3_read | input | 1 | Read of the processor idle-level-3 register |
| evt_sleep_set | input | 1 | Write of 1 to the sleep-enable control |
| evt_throttle_set | input | 1 | Write of 1 to the throttle-enable control |
| evt_smicmd_wr | input | 1 | Write to the SMI command port |
| top_status | output | 16 | Top-level word, summary in bit 2 |
| smi_active | output | 1 | SMI request level |

## Verification
Two things can happen in the same clock edge: a destructive read clearing the status, and a new event setting a status bit. The directed sequence forces this by firing the command-port event together with a read at address 1. It then expects the returned data to show the old word, and the word after the edge to hold only the new bit, with `smi_active` still high. A random phase then mixes strobes, addresses and events freely, so clears, mirror reads, enable writes and events often land on the same edge. A behavioural model of the rules above judges every cycle.

// File: rtl/smi_hub_pkg.sv
package smi_hub_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int EN_W   = 5;

  localparam logic [ADDR_W-1:0] A_MIRROR = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE = 2'd2;
  localparam logic [ADDR_W-1:0] A_TOP    = 2'd3;

  // status bit positions
  localparam int B_CMD  = 0;
  localparam int B_THR  = 1;
  localparam int B_SLP  = 2;
  localparam int B_IDL  = 4;
  localparam int B_BIOS = 5;
  localparam int TOP_SUM_BIT = 2;

  // enable bit positions
  localparam int E_BIOS_A = 0;
  localparam int E_BIOS_B = 1;
  localparam int E_IDL    = 2;
  localparam int E_SLP    = 3;
  localparam int E_THR    = 4;
  localparam logic [EN_W-1:0] EN_RST = 5'b11100;

  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << B_CMD) | (1 << B_THR) |
                                                    (1 << B_SLP) | (1 << B_IDL) |
                                                    (1 << B_BIOS));

  typedef struct packed {
    logic bios;
    logic idle3;
    logic sleep;
    logic thr;
    logic cmd;
  } smi_evt_t;

  // Turn raw events into the set mask for the status word.
  function automatic logic [DATA_W-1:0] gate_events(smi_evt_t ev, logic [EN_W-1:0] en);
    logic [DATA_W-1:0] m;
    m         = '0;
    m[B_BIOS] = ev.bios & en[E_BIOS_A] & en[E_BIOS_B];
    m[B_IDL]  = ev.idle3 & en[E_IDL];
    m[B_SLP]  = ev.sleep & en[E_SLP];
    m[B_THR]  = ev.thr & en[E_THR];
    m[B_CMD]  = ev.cmd;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] top_word(logic [DATA_W-1:0] stat);
    logic [DATA_W-1:0] w;
    w              = '0;
    w[TOP_SUM_BIT] = |stat;
    return w;
  endfunction
endpackage

// File: rtl/smi_en_regs.sv
module smi_en_regs
  import smi_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en
);
  logic            en_wr;
  logic [EN_W-1:0] en_q;
  logic            unused_hi;

  assign en_wr     = wr && (addr == A_ENABLE);
  assign unused_hi = ^wdata[DATA_W-1:EN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= EN_RST;
    else if (en_wr) en_q <= wdata[EN_W-1:0];
  end

  assign en = en_q;

  a_r11_en_write_elsewhere_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != A_ENABLE) |=> $stable(en_q));
  a_r12_en_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_ENABLE) |=> (en_q == $past(wdata[EN_W-1:0])));
endmodule

// File: rtl/smi_stat_latch.sv
module smi_stat_latch
  import smi_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_rd,
  input  logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] status,
  output logic              any_next
);
  logic [DATA_W-1:0] st_q;
  logic [DATA_W-1:0] st_nxt;

  // a new event wins over a clear in the same cycle
  assign st_nxt   = ((clr_rd ? '0 : st_q) | set_mask) & IMPL_MASK;
  assign any_next = |st_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_nxt;
  end

  assign status = st_q;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL_MASK) == '0);
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && set_mask == '0) |=> (status == '0));
  a_r8_event_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> ((status & $past(set_mask & IMPL_MASK)) == $past(set_mask & IMPL_MASK)));
  a_r6_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_rd && set_mask == '0) |=> $stable(status));
endmodule

// File: rtl/smi_rd_mux.sv
module smi_rd_mux
  import smi_hub_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] top,
  input  logic [EN_W-1:0]   en,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    unique case (addr)
      A_MIRROR, A_CLEAR: rdata = status;
      A_ENABLE:          rdata = DATA_W'(en);
      default:           rdata = top;
    endcase
  end
endmodule

// File: rtl/smi_status_hub.sv
module smi_status_hub
  import smi_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              evt_bios_raise,
  input  logic              evt_idle3_read,
  input  logic              evt_sleep_set,
  input  logic              evt_throttle_set,
  input  logic              evt_smicmd_wr,
  output logic [15:0]       top_status,
  output logic              smi_active
);
  // named internal events
  logic              clr_rd;
  logic              mirror_rd;
  smi_evt_t          ev;
  logic [EN_W-1:0]   en;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] status;
  logic              any_next;
  logic              smi_q;

  assign clr_rd    = reg_rd && (reg_addr == A_CLEAR);
  assign mirror_rd = reg_rd && (reg_addr == A_MIRROR);
  assign ev        = '{bios: evt_bios_raise, idle3: evt_idle3_read, sleep: evt_sleep_set,
                       thr: evt_throttle_set, cmd: evt_smicmd_wr};
  assign set_mask  = gate_events(ev, en);

  smi_en_regs u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .en    (en)
  );

  smi_stat_latch u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_rd   (clr_rd),
    .set_mask (set_mask),
    .status   (status),
    .any_next (any_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_q <= 1'b0;
    else        smi_q <= any_next;
  end

  assign smi_active = smi_q;
  assign top_status = top_word(status);

  smi_rd_mux u_mux (
    .addr   (reg_addr),
    .status (status),
    .top    (top_status),
    .en     (en),
    .rdata  (reg_rdata)
  );

  a_r10_smi_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
    smi_active == (status != '0));
  a_r6_mirror_keeps_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_rd && smi_active) |=> smi_active);
  a_r3_bios_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en[E_BIOS_A] && en[E_BIOS_B]) && !status[B_BIOS]) |=> !status[B_BIOS]);
  a_r5_cmd_always_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_smicmd_wr |=> (status[B_CMD] && smi_active));
  a_r9_top_only_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (top_status & ~(16'h1 << TOP_SUM_BIT)) == 16'h0);
endmodule

// File: tb/tb_smi_status_hub.sv
`timescale 1ns/1ps
module tb_smi_status_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata, top_status;
  logic        smi_active;
  logic [4:0]  evs = 5'b0; // {bios, idle3, sleep, throttle, cmd}

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smi_status_hub dut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_bios_raise(evs[4]), .evt_idle3_read(evs[3]), .evt_sleep_set(evs[2]),
    .evt_throttle_set(evs[1]), .evt_smicmd_wr(evs[0]),
    .top_status(top_status), .smi_active(smi_active));

  // behavioural reference model
  int m_stat, m_en;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 0;
      m_en   <= 28;
    end else begin
      int s;
      s = (reg_rd && reg_addr == 2'd1) ? 0 : m_stat;
      if (evs[4] && (m_en % 2 == 1) && ((m_en / 2) % 2 == 1)) s = s | 32;
      if (evs[3] && ((m_en / 4) % 2 == 1))  s = s | 16;
      if (evs[2] && ((m_en / 8) % 2 == 1))  s = s | 4;
      if (evs[1] && ((m_en / 16) % 2 == 1)) s = s | 2;
      if (evs[0]) s = s | 1;
      m_stat <= s;
      if (reg_wr && reg_addr == 2'd2) m_en <= reg_wdata % 32;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int er;
      string tg;
      case (reg_addr)
        2'd0: begin er = m_stat; tg = "R6 mirror"; end
        2'd1: begin er = m_stat; tg = "R7 clear-read data"; end
        2'd2: begin er = m_en;   tg = "R12 enables"; end
        default: begin er = (m_stat != 0) ? 4 : 0; tg = "R9 top word"; end
      endcase
      check({"R13 ", tg}, reg_rdata, er);
      check("R10 smi level", smi_active, (m_stat != 0) ? 1 : 0);
      check("R9 top port", top_status, (m_stat != 0) ? 4 : 0);
    end
  end

  task automatic drive(bit rd, bit wr, logic [1:0] a, logic [15:0] d, logic [4:0] e);
    @(posedge clk); #1;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d; evs = e;
  endtask

  task automatic peek(logic [1:0] a, int exp, string tag);
    drive(0, 0, a, 16'h0, 5'b0);
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    peek(2'd0, 16'h0000, "R1 status after reset");
    peek(2'd2, 16'h001C, "R1 enables after reset");
    check("R1 smi after reset", smi_active, 0);
    check("R1 top after reset", top_status, 0);

    // all events, BIOS-raise enables both 0
    drive(0, 0, 2'd0, 16'h0, 5'b11111);
    peek(2'd0, 16'h0017, "R3 bios blocked, others set");
    check("R4 default enables", reg_rdata & 16'h0016, 16'h0016);

    // destructive read
    drive(1, 0, 2'd1, 16'h0, 5'b0);
    @(negedge clk);
    check("R7 clear read returns old", reg_rdata, 16'h0017);
    peek(2'd0, 16'h0000, "R7 status cleared");
    check("R7 smi dropped", smi_active, 0);
    check("R7 top dropped", top_status, 0);

    // only one BIOS enable
    drive(0, 1, 2'd2, 16'h001D, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b10000);
    peek(2'd0, 16'h0000, "R3 one enable only");
    drive(0, 1, 2'd2, 16'h001F, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b10000);
    peek(2'd0, 16'h0020, "R3 both enables");
    check("R10 smi high", smi_active, 1);
    check("R9 top summary", top_status, 16'h0004);

    // mirror read keeps everything
    drive(1, 0, 2'd0, 16'h0, 5'b0);
    peek(2'd0, 16'h0020, "R6 mirror keeps status");
    check("R6 mirror keeps smi", smi_active, 1);

    // writes to status and top addresses ignored
    drive(0, 1, 2'd0, 16'hFFFF, 5'b0);
    drive(0, 1, 2'd1, 16'hFFFF, 5'b0);
    drive(0, 1, 2'd3, 16'hFFFF, 5'b0);
    peek(2'd0, 16'h0020, "R11 status untouched");
    peek(2'd2, 16'h001F, "R11 enables untouched");

    // clear and event in the same cycle
    drive(1, 0, 2'd1, 16'h0, 5'b00001);
    peek(2'd0, 16'h0001, "R8 event survives clear");
    check("R8 smi stays", smi_active, 1);

    // individual enables
    drive(1, 0, 2'd1, 16'h0, 5'b0);
    drive(0, 1, 2'd2, 16'h0003, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b01110);
    peek(2'd0, 16'h0000, "R4 disabled sources");
    drive(0, 1, 2'd2, 16'h0004, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b01110);
    peek(2'd0, 16'h0010, "R4 idle3 only");
    drive(1, 0, 2'd1, 16'h0, 5'b0);
    drive(0, 1, 2'd2, 16'h0018, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b01110);
    peek(2'd0, 16'h0006, "R4 sleep and throttle");

    // command port with no enables
    drive(1, 0, 2'd1, 16'h0, 5'b0);
    drive(0, 1, 2'd2, 16'h0000, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b00001);
    peek(2'd0, 16'h0001, "R5 cmd without enables");

    // reserved bits
    drive(0, 1, 2'd2, 16'hFFFF, 5'b0);
    drive(0, 0, 2'd0, 16'h0, 5'b11111);
    peek(2'd0, 16'h0037, "R2 all sources set");
    check("R2 reserved zero", reg_rdata & 16'hFFC8, 0);
    peek(2'd2, 16'h001F, "R12 upper bits dropped");
    drive(0, 1, 2'd2, 16'hFFE0, 5'b0);
    peek(2'd2, 16'h0000, "R12 write upper only");

    // random phase, judged by the model each cycle
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] e;
      e = 5'($urandom) & 5'($urandom);
      drive(($urandom % 3) == 0, ($urandom % 8) == 0, 2'($urandom),
            16'($urandom), e);
    end
    drive(0, 0, 2'd0, 16'h0, 5'b0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule